// File: doc/BRIEF.md
# Shifting Register LIFO Stack

This block is a last-in first-out store built from a chain of registers. Stored words physically move along the chain: a push moves every word one stage deeper and writes the new word into the first stage, and a pop moves every word one stage toward the first stage. The first stage is always the top of the stack, so no address or pointer exists anywhere in the design.

Each stage keeps a valid bit that travels with its word. The empty flag is the inverse of the first stage's valid bit, and the full flag is the last stage's valid bit. Illegal requests leave the contents alone and raise a one-cycle error pulse. Width and depth are parameters. All outputs come straight from flip-flops and update one clock after the request.

Top module: `shift_lifo`

## Requirements
- R1: While synchronous reset `rst` is high at a rising edge, the next cycle shows `empty`=1, `full`=0, `top_q`=0, `ovf_err`=0 and `unf_err`=0.
- R2: A push (`push`=1, `pop`=0) on a stack that is not full puts `din` on `top_q` in the cycle after the edge, and `empty` goes to 0.
- R3: Words leave in the reverse of the order in which they were pushed.
- R4: A pop (`pop`=1, `push`=0) on a non-empty stack shows the next older word on `top_q` one cycle later. Popping the last word sets `empty`=1 and `top_q`=0.
- R5: `full` rises after DEPTH words are held and falls after one pop.
- R6: A push alone while `full`=1 changes no stored word, keeps `full`=1, and pulses `ovf_err` high for exactly the next cycle.
- R7: A pop alone while `empty`=1 leaves the stack empty with `top_q`=0, and pulses `unf_err` high for exactly the next cycle.
- R8: Push and pop together on a non-empty stack, whether partly filled or full, replace the top word with `din`. The flags stay the same, no deeper word moves, and no error is raised.
- R9: Push and pop together on an empty stack act as a plain push, with no error.
- R10: Whenever `empty`=1, `top_q` is 0. `empty` and `full` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Push request strobe |
| pop | input | 1 | Pop request strobe |
| din | input | WIDTH | Word to push |
| top_q | output | WIDTH | Word in the top stage, 0 when empty |
| empty | output | 1 | No word held |
| full | output | 1 | DEPTH words held |
| ovf_err | output | 1 | One-cycle pulse: push was refused because the stack was full |
| unf_err | output | 1 | One-cycle pulse: pop was refused because the stack was empty |

## Verification
A stray valid bit shows on `empty` or `full` one cycle after the faulty operation, because each flag is a stage's valid register. A wrong word in a deep stage cannot be seen until enough pops bring it to `top_q`, which can take up to DEPTH pops. For that reason every scenario drains the stack completely and checks each word as it reaches the top. Fill and drain runs to full depth also show whether invalid stages hold zero, since that zero appears on `top_q` when the stack empties.

// File: rtl/lifo_pkg.sv
package lifo_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } lifo_op_e;
endpackage

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
  import lifo_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     push,
  input  logic     pop,
  input  logic     empty,
  input  logic     full,
  output lifo_op_e op,
  output logic     ovf_err,
  output logic     unf_err
);
  always_comb begin
    op = OP_HOLD;
    if (push && pop)      op = empty ? OP_PUSH : OP_SWAP;
    else if (push)        op = full ? OP_HOLD : OP_PUSH;
    else if (pop)         op = empty ? OP_HOLD : OP_POP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_err <= 1'b0;
      unf_err <= 1'b0;
    end else begin
      ovf_err <= push && !pop && full;
      unf_err <= pop && !push && empty;
    end
  end
endmodule

// File: rtl/lifo_stage.sv
module lifo_stage
  import lifo_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit IS_HEAD = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  lifo_op_e         op,
  input  logic [WIDTH-1:0] up_d,
  input  logic             up_v,
  input  logic [WIDTH-1:0] dn_d,
  input  logic             dn_v,
  output logic [WIDTH-1:0] q_d,
  output logic             q_v
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_d <= '0;
      q_v <= 1'b0;
    end else begin
      unique case (op)
        OP_PUSH: begin
          q_d <= up_d;
          q_v <= up_v;
        end
        OP_POP: begin
          q_d <= dn_d;
          q_v <= dn_v;
        end
        OP_SWAP: begin
          if (IS_HEAD) q_d <= up_d;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/shift_lifo.sv
module shift_lifo
  import lifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] top_q,
  output logic             empty,
  output logic             full,
  output logic             ovf_err,
  output logic             unf_err
);
  localparam int CHAIN = DEPTH + 2;

  logic [WIDTH-1:0] chain_d [CHAIN];
  logic             chain_v [CHAIN];
  lifo_op_e         op;

  assign chain_d[0]       = din;
  assign chain_v[0]       = 1'b1;
  assign chain_d[CHAIN-1] = '0;
  assign chain_v[CHAIN-1] = 1'b0;

  lifo_ctrl u_ctrl (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .empty(empty), .full(full), .op(op),
    .ovf_err(ovf_err), .unf_err(unf_err)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    lifo_stage #(.WIDTH(WIDTH), .IS_HEAD(i == 0)) u_stage (
      .clk(clk), .rst(rst), .op(op),
      .up_d(chain_d[i]),   .up_v(chain_v[i]),
      .dn_d(chain_d[i+2]), .dn_v(chain_v[i+2]),
      .q_d(chain_d[i+1]),  .q_v(chain_v[i+1])
    );
  end

  assign top_q = chain_d[1];
  assign empty = !chain_v[1];
  assign full  = chain_v[DEPTH];
endmodule

// File: rtl/lifo_chk.sv
module lifo_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             push,
  input logic             pop,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] top_q,
  input logic             empty,
  input logic             full,
  input logic             ovf_err,
  input logic             unf_err
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (empty && !full && top_q == '0 && !ovf_err && !unf_err)); // R1
  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (rst) (push && !pop && !full) |=> (top_q == $past(din) && !empty)); // R2
  AST_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (push && !pop && full) |=> (ovf_err && full && $stable(top_q))); // R6
  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) (pop && !push && empty) |=> (unf_err && empty)); // R7
  AST_SWAP_TOP: assert property (@(posedge clk) disable iff (rst) (push && pop && !empty) |=> (top_q == $past(din) && $stable(full) && !empty && !ovf_err && !unf_err)); // R8
  AST_BOTH_EMPTY: assert property (@(posedge clk) disable iff (rst) (push && pop && empty) |=> (top_q == $past(din) && !empty && !unf_err)); // R9
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst) empty |-> (top_q == '0 && !full)); // R10
endmodule

bind shift_lifo lifo_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .push(push), .pop(pop), .din(din),
  .top_q(top_q), .empty(empty), .full(full),
  .ovf_err(ovf_err), .unf_err(unf_err)
);

// File: tb/shift_lifo_test.sv
module shift_lifo_test;
  localparam int W = 8;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push = 1'b0;
  logic pop = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] top_q;
  logic empty, full, ovf_err, unf_err;
  int runs = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  shift_lifo #(.WIDTH(W), .DEPTH(D)) uut (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .din(din),
    .top_q(top_q), .empty(empty), .full(full),
    .ovf_err(ovf_err), .unf_err(unf_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit p, input bit q, input logic [W-1:0] d);
    @(negedge clk);
    push = p; pop = q; din = d;
    @(posedge clk); #1;
    push = 1'b0; pop = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 empty", empty, 1); chk("R1 full", full, 0);
    chk("R1 top", top_q, 0);
    chk("R1 ovf", ovf_err, 0); chk("R1 unf", unf_err, 0);
    chk("R10 empty top zero", top_q, 0);
  endtask

  task automatic t_order();
    do_reset();
    step(1, 0, 8'h11); chk("R2 top", top_q, 8'h11); chk("R2 empty", empty, 0);
    step(1, 0, 8'h22); chk("R2 top", top_q, 8'h22);
    step(1, 0, 8'h33); chk("R2 top", top_q, 8'h33);
    step(0, 1, 0); chk("R3 pop1", top_q, 8'h22);
    step(0, 1, 0); chk("R3 pop2", top_q, 8'h11); chk("R4 not empty", empty, 0);
    step(0, 1, 0); chk("R4 empty", empty, 1); chk("R4 top zero", top_q, 0);
  endtask

  task automatic t_fill();
    do_reset();
    for (int i = 1; i <= D; i++) begin
      step(1, 0, W'(8'hA0 + i));
      chk("R5 full timing", full, (i == D) ? 1 : 0);
    end
    step(1, 0, 8'hEE);
    chk("R6 ovf pulse", ovf_err, 1); chk("R6 full kept", full, 1);
    chk("R6 top kept", top_q, 8'hA0 + D);
    step(0, 0, 0); chk("R6 ovf one cycle", ovf_err, 0);
    for (int i = D; i >= 1; i--) begin
      chk("R3 R6 drain", top_q, 8'hA0 + i);
      step(0, 1, 0);
      if (i == D) chk("R5 full falls", full, 0);
    end
    chk("R4 drained", empty, 1); chk("R10 top zero", top_q, 0);
  endtask

  task automatic t_underflow();
    do_reset();
    step(0, 1, 0);
    chk("R7 unf pulse", unf_err, 1); chk("R7 empty", empty, 1);
    chk("R7 top zero", top_q, 0); chk("R10 not full", full, 0);
    step(0, 0, 0); chk("R7 unf one cycle", unf_err, 0);
  endtask

  task automatic t_swap();
    do_reset();
    step(1, 0, 8'h05); step(1, 0, 8'h06);
    step(1, 1, 8'h09);
    chk("R8 top replaced", top_q, 8'h09); chk("R8 full", full, 0);
    chk("R8 no error", ovf_err | unf_err, 0);
    step(0, 1, 0); chk("R8 deeper kept", top_q, 8'h05);
    step(0, 1, 0); chk("R8 depth kept", empty, 1);
    for (int i = 1; i <= D; i++) step(1, 0, W'(i));
    step(1, 1, 8'h77);
    chk("R8 full swap top", top_q, 8'h77); chk("R8 full kept", full, 1);
    chk("R8 full no ovf", ovf_err, 0);
    for (int i = D - 1; i >= 1; i--) begin
      step(0, 1, 0); chk("R8 full deeper", top_q, i);
    end
    step(0, 1, 0); chk("R8 full drained", empty, 1);
  endtask

  task automatic t_both_empty();
    do_reset();
    step(1, 1, 8'h44);
    chk("R9 top", top_q, 8'h44); chk("R9 empty", empty, 0);
    chk("R9 no unf", unf_err, 0);
    step(0, 1, 0); chk("R9 single word", empty, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_order();
    t_fill();
    t_underflow();
    t_swap();
    t_both_empty();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule